// File: doc/BRIEF.md
# Banked Byte Memory Target on a Two-Wire Serial Bus

This block is an I2C target that holds a 1 KiB byte memory split into four banks of 256 bytes. The master picks a bank with two bits inside the slave address byte. An 8-bit word address then names a location within that bank. The block supports four transfers: byte writes, multi-byte writes made of consecutive byte writes, reads from the current address, and random reads (a write-direction address phase, then a repeated START in read direction). Any read can go on as a sequential read for as long as the master acknowledges each byte.

Both bus lines are sampled on a fast system clock through two-flop synchronizers. The block pulls the data line low through an output enable and never drives it high. A single address pointer is shared by all transfers. Where a current read starts depends on the command before it: after a read it starts at the next location, and after a write it starts at the byte written last. The pointer always wraps inside the selected bank.

Top module: `i2c_bank_mem`

## Requirements
- R1: After reset `sda_oe` is low, the block is idle and every memory byte reads as 0x00. The pointer is 0 and the last command counts as a read, so a current read of bank 0 returns the byte at address 0x00.
- R2: The address byte is laid out as follows:
  - bits [7:4] must equal 1010;
  - bits [3:2] select the bank;
  - bit 1 is ignored;
  - bit 0 is the direction (1 = read).

  A matching byte is acknowledged (SDA low in the ninth clock). On a mismatch the block leaves SDA released and ignores the bus until the next START, and memory is not changed.
- R3: In write direction, the first byte after the address is the word address. Each following data byte is acknowledged and stored at that location in the selected bank. Consecutive data bytes go to consecutive locations, wrapping from 0xFF to 0x00 within the bank.
- R4: A random read returns the byte at the word address given in the write phase before the repeated START.
- R5: After any read, a current read returns the byte one past the last byte read, wrapping within the bank.
- R6: After a write, a current read returns the byte at the address written last.
- R7: A master ACK after a byte makes the block send the next location. A NACK followed by STOP ends the read. Sequential reads wrap from 0xFF to 0x00 inside the same bank.
- R8: SDA is only ever pulled low. The output enable changes only while SCL is low, except when a START or STOP releases it. The line is released during the master's acknowledge slot.
- R9: A START received while a transfer is in progress, including a repeated START, returns the block to the address phase.
- R10: Read data leaves MSB first, one bit per SCL clock, with 8 bits per byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | High pulls SDA low; low releases it |

## Verification
The case hardest to reach from the pins is a current read that follows a write. The pointer has already moved past the written byte, so only the remembered command type makes the read land on the written location. The bench reaches this in two ways. Directed sequences write a byte and then issue a repeated START in read direction, with and without a STOP between them. Random traffic mixes writes, random reads and current reads in any order across banks, and a bench model predicts every read byte. A directed read from address 0xFE over four bytes forces the wrap at the top of a bank, and an address-mismatch sequence followed by a read-back confirms that memory was left alone.

// File: rtl/i2c_bank_mem.sv
`timescale 1ns/1ps
module i2c_bank_mem #(
  parameter int AW = 8,
  parameter int BW = 2,
  parameter logic [3:0] DEV_ID = 4'b1010
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int DEPTH = 1 << (AW + BW);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} st_t;
  typedef enum logic [1:0] {K_DEV, K_WORD, K_DATA} kind_t;

  logic [1:0] scl_sy, sda_sy;
  logic scl_q, sda_q;
  wire scl_s = scl_sy[1];
  wire sda_s = sda_sy[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end

  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;

  st_t            state;
  kind_t          kind;
  logic [3:0]     cnt;
  logic [7:0]     sh;
  logic           ack_en, rw, wr_flag, mack;
  logic [BW-1:0]  bank;
  logic [AW-1:0]  ptr, last_wr;
  logic [7:0]     mem [DEPTH];

  wire [AW-1:0] cur_addr = wr_flag ? last_wr : ptr;
  wire [7:0]    cur_byte = mem[{bank, cur_addr}];
  wire          dev_hit  = (sh[7:4] == DEV_ID);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; kind <= K_DEV; cnt <= '0; sh <= '0;
      ack_en <= 1'b0; rw <= 1'b0; wr_flag <= 1'b0; mack <= 1'b0;
      bank <= '0; ptr <= '0; last_wr <= '0; sda_oe <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (start_c) begin
      state <= S_RX; kind <= K_DEV; cnt <= '0; sda_oe <= 1'b0;
    end else if (stop_c) begin
      state <= S_IDLE; sda_oe <= 1'b0;
    end else begin
      case (state)
        S_RX: begin
          if (scl_rise) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            state <= S_ACK;
            case (kind)
              K_DEV: begin
                ack_en <= dev_hit;
                sda_oe <= dev_hit;
                if (dev_hit) begin
                  bank <= sh[2 +: BW];
                  rw   <= sh[0];
                end
              end
              K_WORD: begin
                ptr <= sh[AW-1:0]; wr_flag <= 1'b0;
                ack_en <= 1'b1; sda_oe <= 1'b1;
              end
              default: begin
                mem[{bank, ptr}] <= sh;
                last_wr <= ptr; ptr <= ptr + 1'b1; wr_flag <= 1'b1;
                ack_en <= 1'b1; sda_oe <= 1'b1;
              end
            endcase
          end
        end
        S_ACK: if (scl_fall) begin
          cnt <= '0;
          if (!ack_en) begin
            state <= S_IDLE; sda_oe <= 1'b0;
          end else if (kind == K_DEV && rw) begin
            sh <= cur_byte; ptr <= cur_addr + 1'b1; wr_flag <= 1'b0;
            sda_oe <= ~cur_byte[7]; state <= S_TX;
          end else begin
            kind <= (kind == K_DEV) ? K_WORD : K_DATA;
            sda_oe <= 1'b0; state <= S_RX;
          end
        end
        S_TX: begin
          if (scl_rise) cnt <= cnt + 4'd1;
          else if (scl_fall) begin
            if (cnt == 4'd8) begin
              state <= S_MACK; sda_oe <= 1'b0;
            end else begin
              sh <= {sh[6:0], 1'b0}; sda_oe <= ~sh[6];
            end
          end
        end
        S_MACK: begin
          if (scl_rise) mack <= ~sda_s;
          else if (scl_fall) begin
            cnt <= '0;
            if (mack) begin
              sh <= cur_byte; ptr <= cur_addr + 1'b1;
              sda_oe <= ~cur_byte[7]; state <= S_TX;
            end else begin
              state <= S_IDLE; sda_oe <= 1'b0;
            end
          end
        end
        default: sda_oe <= 1'b0;
      endcase
    end

  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_IDLE |-> !sda_oe);
  p_nack_mismatch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ACK && !ack_en) |-> !sda_oe);
  p_seq_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TX && $past(state) == S_MACK) |-> ptr == AW'($past(ptr) + 1'b1));
  p_oe_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe) && !$past(start_c) && !$past(stop_c)) |-> !scl_s);
  p_mack_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_MACK |-> !sda_oe);
  p_start_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (state == S_RX && kind == K_DEV && cnt == 4'd0));
  p_bitcount_r10: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_TX |-> cnt <= 4'd8);
endmodule

// File: tb/i2c_bank_mem_test.sv
`timescale 1ns/1ps
module i2c_bank_mem_test;
  localparam int CLK_NS = 10;
  localparam int Q = 5 * CLK_NS;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0;
  logic sda_oe;
  wire sda_line = !(sda_oe || m_low);

  i2c_bank_mem uut (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe));

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] mdl [1024];
  int mptr = 0, mlast = 0;
  bit mwf = 0;

  function automatic int cur_addr();
    return mwf ? mlast : mptr;
  endfunction

  function automatic logic [7:0] dev_byte(input int bank, input bit rw);
    return {4'b1010, 2'(bank), 1'($urandom % 2), rw};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clk_bit(input bit b, output bit s);
    m_low = !b; #(Q);
    scl = 1'b1; #(Q);
    s = sda_line; #(Q);
    scl = 1'b0; #(Q);
  endtask

  task automatic i2c_start();
    m_low = 1'b0; #(Q);
    scl = 1'b1; #(Q);
    m_low = 1'b1; #(Q);
    scl = 1'b0; #(Q);
  endtask

  task automatic i2c_stop();
    m_low = 1'b1; #(Q);
    scl = 1'b1; #(Q);
    m_low = 1'b0; #(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    bit s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    acked = !s;
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] d);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      d[i] = s;
    end
    clk_bit(!ack, s);
  endtask

  task automatic do_write(input int bank, input int wa, input int n, input bit stop);
    bit a;
    logic [7:0] d;
    i2c_start();
    send_byte(dev_byte(bank, 1'b0), a); chk(a, "R2 address ack", a, 1);
    send_byte(8'(wa), a);               chk(a, "R3 word ack", a, 1);
    mptr = wa; mwf = 0;
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      send_byte(d, a); chk(a, "R3 data ack", a, 1);
      mdl[bank*256 + mptr] = d;
      mlast = mptr; mptr = (mptr + 1) % 256; mwf = 1;
    end
    if (stop) i2c_stop();
  endtask

  task automatic do_read(input int bank, input bit rnd, input int wa, input int n, input string tag);
    bit a;
    logic [7:0] d, e;
    if (rnd) begin
      i2c_start();
      send_byte(dev_byte(bank, 1'b0), a); chk(a, "R2 address ack", a, 1);
      send_byte(8'(wa), a);               chk(a, "R4 word ack", a, 1);
      mptr = wa; mwf = 0;
    end
    i2c_start();
    send_byte(dev_byte(bank, 1'b1), a); chk(a, "R9 read address ack", a, 1);
    for (int i = 0; i < n; i++) begin
      e = mdl[bank*256 + cur_addr()];
      mptr = (cur_addr() + 1) % 256; mwf = 0;
      recv_byte(i < n-1, d);
      chk(d === e, tag, d, e);
    end
    i2c_stop();
  endtask

  initial begin
    bit a;
    for (int i = 0; i < 1024; i++) mdl[i] = 8'h00;
    void'($urandom(32'h5eed));
    #(CLK_NS*5); rst_n = 1'b1; #(CLK_NS*5);
    chk(sda_oe == 1'b0, "R1 oe after reset", sda_oe, 0);
    do_read(0, 0, 0, 2, "R1 current read after reset");

    // R2 mismatch: no ack, following bytes ignored
    i2c_start();
    send_byte(8'b0110_0100, a); chk(!a, "R2 mismatch nack", a, 0);
    send_byte(8'h10, a);        chk(!a, "R2 ignored after mismatch", a, 0);
    send_byte(8'h5A, a);        chk(!a, "R2 ignored after mismatch", a, 0);
    i2c_stop();
    do_read(1, 1, 8'h10, 1, "R2 memory untouched");

    // R10 MSB first, R6 current read after write
    do_write(2, 8'h40, 1, 1);
    mdl[2*256 + 8'h40] = 8'h80;
    i2c_start();
    send_byte(dev_byte(2, 1'b0), a); send_byte(8'h40, a); send_byte(8'h80, a); i2c_stop();
    mlast = 8'h40; mptr = 8'h41; mwf = 1;
    do_read(2, 0, 0, 1, "R10 R6 current read after write");
    do_read(2, 0, 0, 1, "R5 current read after read");

    // R9 repeated start right after a data byte, R6
    do_write(3, 8'h22, 3, 0);
    do_read(3, 0, 0, 2, "R9 R6 repeated start after write");

    // R7 wrap inside bank, R3 page write wrap
    do_write(1, 8'hFE, 4, 1);
    do_read(1, 1, 8'hFE, 4, "R7 R3 sequential wrap in bank");
    do_read(1, 0, 0, 2, "R5 current after sequential");

    for (int k = 0; k < 30; k++) begin
      int op, bk, wa, n;
      op = $urandom % 3; bk = $urandom % 4; wa = $urandom % 256; n = 1 + $urandom % 4;
      case (op)
        0: do_write(bk, wa, n, 1);
        1: do_read(bk, 1, wa, n, "R4 random read");
        default: do_read(bk, 0, 0, n, "R5 R6 current read");
      endcase
    end
    chk(sda_oe == 1'b0, "R8 released at end", sda_oe, 0);
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 190000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule